// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command engine of a serial NOR flash target. While chip select is low, each transfer strobe delivers one received byte. The engine answers every accepted byte with one response byte, one cycle later. The first byte after selection is the opcode. For addressed operations, the engine then shifts in the address most significant byte first. After that it either streams stored bytes out or programs incoming bytes into a byte-wide synchronous memory.

The memory is driven through a read address, a write address, write data and a write strobe. Read data comes back one clock after the read address. Programming is a read-modify-write that can only clear bits. The address advances after every data byte and wraps at the device size. Supported opcodes are plain read, fast read with dummy bytes, page program, status write, status read, and entry and exit of four-byte addressing.

Top module: `snor_cmd_seq`

## Requirements
- R1: After reset `resp_vld` and `mem_we` are low, the engine waits for an opcode, addressing is three bytes, and the status byte is zero.
- R2: Opcode 0x03 followed by the address bytes (MSB first, truncated to the low ADDR_W bits) makes every further byte in the selection return the stored byte at the current address. The address then increments, wrapping from 2^ADDR_W-1 to 0.
- R3: Opcode 0x0B works like R2, except that DUMMY_BYTES extra bytes (default 1) follow the address. Those bytes answer 0x00 before any data is returned.
- R4: Opcode 0x02 followed by the address makes each further byte store (old AND received) at the current address. The address then increments with the same wrap as R2.
- R5: Opcode 0x01 stores the next byte as the status byte. Opcode 0x05 answers every further byte of the selection with the status byte, its bit 0 forced to 0.
- R6: Opcode 0xB7 selects four-byte addressing and opcode 0xE9 returns to three-byte addressing. Both act at once, with no data bytes, and the mode persists across selections.
- R7: Any other opcode makes the rest of the selection answer 0x00. Those later bytes are not decoded and change nothing.
- R8: While `cs_n` is high, strobes produce no response and no memory write. Raising `cs_n` ends any phase, so the first byte of the next selection is decoded as an opcode.
- R9: Opcode, address and program bytes answer 0x00. `resp_vld` pulses exactly once, one cycle after each accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| stb | input | 1 | One-cycle transfer strobe for `rx_byte` |
| rx_byte | input | 8 | Received byte |
| resp_vld | output | 1 | Response byte valid (one cycle) |
| resp_byte | output | 8 | Response byte |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Memory read data, one clock after `mem_raddr` |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |

## Verification
The checks assume a gap of at least one idle cycle between strobes. This gives the synchronous memory time to present data for the current address before the next byte is accepted. The stimulus meets this by giving each strobe a single cycle followed by three quiet cycles. The checks also assume that `cs_n` changes only between strobes, so every selection boundary falls on a quiet cycle. The stimulus keeps to this by moving `cs_n` only when no strobe is in flight. It also strobes once on purpose while deselected, to show that such strobes are ignored.

// File: rtl/snor_pkg.sv
package snor_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_PROG,
      ST_READ,
      ST_RBACK
   } snor_state_e;

   typedef enum logic [2:0] {
      K_READ,
      K_FAST,
      K_PROG,
      K_RDSR,
      K_WRSR,
      K_EN4,
      K_EX4,
      K_BAD
   } snor_kind_e;

   localparam logic [7:0] OPC_READ = 8'h03;
   localparam logic [7:0] OPC_FAST = 8'h0B;
   localparam logic [7:0] OPC_PROG = 8'h02;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_WRSR = 8'h01;
   localparam logic [7:0] OPC_EN4  = 8'hB7;
   localparam logic [7:0] OPC_EX4  = 8'hE9;

endpackage

// File: rtl/snor_op_decode.sv
module snor_op_decode
   import snor_pkg::*;
#(
   parameter int DUMMY_BYTES = 1,
   parameter int CNT_W       = 5
) (
   input  logic [7:0]       opc,
   input  logic             four,
   output snor_kind_e       kind,
   output logic [CNT_W-1:0] need
);

   logic [CNT_W-1:0] alen;

   always_comb begin
      alen = four ? CNT_W'(4) : CNT_W'(3);
      unique case (opc)
         OPC_READ: kind = K_READ;
         OPC_FAST: kind = K_FAST;
         OPC_PROG: kind = K_PROG;
         OPC_RDSR: kind = K_RDSR;
         OPC_WRSR: kind = K_WRSR;
         OPC_EN4:  kind = K_EN4;
         OPC_EX4:  kind = K_EX4;
         default:  kind = K_BAD;
      endcase
      unique case (kind)
         K_READ, K_PROG: need = alen;
         K_FAST:         need = alen + CNT_W'(DUMMY_BYTES);
         K_WRSR:         need = CNT_W'(1);
         default:        need = '0;
      endcase
   end

endmodule

// File: rtl/snor_addr_reg.sv
module snor_addr_reg #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic              incr,
   input  logic [7:0]        byte_in,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W+7:0] shifted;

   assign shifted = {addr, byte_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr <= '0;
      else if (clr)   addr <= '0;
      else if (shift) addr <= shifted[ADDR_W-1:0];
      else if (incr)  addr <= addr + 1'b1;
   end

endmodule

// File: rtl/snor_cmd_seq.sv
module snor_cmd_seq
   import snor_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DUMMY_BYTES = 1,
   parameter int COLL_DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              stb,
   input  logic [7:0]        rx_byte,
   output logic              resp_vld,
   output logic [7:0]        resp_byte,
   output logic [ADDR_W-1:0] mem_raddr,
   input  logic [7:0]        mem_rdata,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we
);

   localparam int CNT_W    = $clog2(COLL_DEPTH + 1);
   localparam int MAX_NEED = 4 + DUMMY_BYTES;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("snor_cmd_seq: ADDR_W must lie in 8..32");
      end
      if (COLL_DEPTH < MAX_NEED) begin : g_bad_depth
         $error("snor_cmd_seq: COLL_DEPTH too small for address plus dummy bytes");
      end
      if (DUMMY_BYTES < 0) begin : g_bad_dummy
         $error("snor_cmd_seq: DUMMY_BYTES must not be negative");
      end
   endgenerate

   snor_state_e      state_q;
   snor_kind_e       kind_q;
   snor_kind_e       dec_kind;
   logic [CNT_W-1:0] dec_need;
   logic [CNT_W-1:0] need_q;
   logic [CNT_W-1:0] cnt_q;
   logic             four_q;
   logic [7:0]       stat_q;
   logic [7:0]       rb_q;
   logic             hit;
   logic             a_clr, a_shift, a_incr;
   logic [CNT_W-1:0] alen;
   logic [ADDR_W-1:0] cur_addr;

   assign hit  = stb && !cs_n;
   assign alen = four_q ? CNT_W'(4) : CNT_W'(3);

   snor_op_decode #(
      .DUMMY_BYTES (DUMMY_BYTES),
      .CNT_W       (CNT_W)
   ) u_dec (
      .opc  (rx_byte),
      .four (four_q),
      .kind (dec_kind),
      .need (dec_need)
   );

   assign a_clr   = hit && (state_q == ST_IDLE);
   assign a_shift = hit && (state_q == ST_COLLECT) && (kind_q != K_WRSR) && (cnt_q < alen);
   assign a_incr  = hit && ((state_q == ST_READ) || (state_q == ST_PROG));

   snor_addr_reg #(
      .ADDR_W (ADDR_W)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (a_clr),
      .shift   (a_shift),
      .incr    (a_incr),
      .byte_in (rx_byte),
      .addr    (cur_addr)
   );

   assign mem_raddr = cur_addr;
   assign mem_waddr = cur_addr;
   assign mem_wdata = rx_byte & mem_rdata;
   assign mem_we    = hit && (state_q == ST_PROG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= K_BAD;
         need_q    <= '0;
         cnt_q     <= '0;
         four_q    <= 1'b0;
         stat_q    <= 8'h00;
         rb_q      <= 8'h00;
         resp_vld  <= 1'b0;
         resp_byte <= 8'h00;
      end else begin
         resp_vld <= hit;
         if (hit) begin
            unique case (state_q)
               ST_READ:  resp_byte <= mem_rdata;
               ST_RBACK: resp_byte <= rb_q;
               default:  resp_byte <= 8'h00;
            endcase
         end
         if (cs_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else if (hit) begin
            unique case (state_q)
               ST_IDLE: begin
                  kind_q <= dec_kind;
                  need_q <= dec_need;
                  cnt_q  <= '0;
                  unique case (dec_kind)
                     K_READ, K_FAST, K_PROG, K_WRSR: state_q <= ST_COLLECT;
                     K_RDSR: begin
                        rb_q    <= {stat_q[7:1], 1'b0};
                        state_q <= ST_RBACK;
                     end
                     K_EN4: four_q <= 1'b1;
                     K_EX4: four_q <= 1'b0;
                     default: begin
                        rb_q    <= 8'h00;
                        state_q <= ST_RBACK;
                     end
                  endcase
               end
               ST_COLLECT: begin
                  if (kind_q == K_WRSR) begin
                     stat_q  <= rx_byte;
                     state_q <= ST_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q + 1'b1 == need_q)
                        state_q <= (kind_q == K_PROG) ? ST_PROG : ST_READ;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/snor_cmd_seq_chk.sv
module snor_cmd_seq_chk
   import snor_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              stb,
   input snor_state_e       state_q,
   input logic              four_q,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_raddr,
   input logic              resp_vld
);

   AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> state_q == ST_IDLE); // R8

   AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !mem_we); // R8

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !cs_n && (state_q == ST_READ || state_q == ST_PROG))
      |=> mem_raddr == ADDR_W'($past(mem_raddr) + 1'b1)); // R2 R4

   AST_RESP_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      resp_vld |-> $past(stb && !cs_n)); // R9

   AST_MODE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && !cs_n) |=> $stable(four_q)); // R6

endmodule

bind snor_cmd_seq snor_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .stb       (stb),
   .state_q   (state_q),
   .four_q    (four_q),
   .mem_we    (mem_we),
   .mem_raddr (mem_raddr),
   .resp_vld  (resp_vld)
);

// File: tb/tb_snor_cmd_seq.sv
module tb_snor_cmd_seq;

   localparam int AW    = 10;
   localparam int MEMSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          stb = 1'b0;
   logic [7:0]    rx_byte = 8'h00;
   logic          resp_vld;
   logic [7:0]    resp_byte;
   logic [AW-1:0] mem_raddr, mem_waddr;
   logic [7:0]    mem_rdata = 8'h00;
   logic [7:0]    mem_wdata;
   logic          mem_we;

   logic [7:0] mem     [MEMSZ];
   logic [7:0] exp_mem [MEMSZ];

   int tests = 0;
   int fails = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #10 clk = ~clk;

   snor_cmd_seq #(.ADDR_W(AW), .DUMMY_BYTES(1), .COLL_DEPTH(16)) dut (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .stb (stb), .rx_byte (rx_byte),
      .resp_vld (resp_vld), .resp_byte (resp_byte),
      .mem_raddr (mem_raddr), .mem_rdata (mem_rdata),
      .mem_waddr (mem_waddr), .mem_wdata (mem_wdata), .mem_we (mem_we)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_waddr] <= mem_wdata;
      mem_rdata <= mem[mem_raddr];
   end

   // monitor: pops expected responses as the design produces them
   always @(negedge clk) begin
      if (rst_n && resp_vld) begin
         tests++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R9/R8: unexpected response %02h, expected none", resp_byte);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            if (resp_byte !== e) begin
               fails++;
               $display("FAIL %s: response %02h, expected %02h", t, resp_byte, e);
            end
         end
      end
   end

   task automatic xfer(input logic [7:0] b, input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk); stb = 1'b1; rx_byte = b;
      @(negedge clk); stb = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic ghost(input logic [7:0] b);
      @(negedge clk); stb = 1'b1; rx_byte = b;
      @(negedge clk); stb = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic sel();
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic desel();
      @(negedge clk); cs_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic addr3(input int a, input string t);
      xfer(8'(a >> 16), 8'h00, t);
      xfer(8'(a >> 8),  8'h00, t);
      xfer(8'(a),       8'h00, t);
   endtask

   task automatic rd_check(input int a, input int n, input string t);
      sel();
      xfer(8'h03, 8'h00, "R9");
      addr3(a, "R9");
      for (int i = 0; i < n; i++) xfer(8'hFF, exp_mem[(a + i) % MEMSZ], t);
      desel();
   endtask

   initial begin
      for (int i = 0; i < MEMSZ; i++) begin
         mem[i]     = 8'(i * 7 + 3);
         exp_mem[i] = 8'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      tests++;
      if (resp_vld !== 1'b0 || mem_we !== 1'b0) begin
         fails++;
         $display("FAIL R1: resp_vld=%b mem_we=%b, expected 0 0", resp_vld, mem_we);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: status reads zero after reset
      sel(); xfer(8'h05, 8'h00, "R9"); xfer(8'h00, 8'h00, "R1"); desel();

      // R2: plain read, then masked address that wraps past the top
      rd_check(32'h000010, 3, "R2");
      rd_check(32'hFFFFFE, 3, "R2");

      // R3: fast read with one dummy byte
      sel();
      xfer(8'h0B, 8'h00, "R9");
      addr3(32'h20, "R9");
      xfer(8'hAA, 8'h00, "R3");
      xfer(8'hFF, exp_mem[32'h20], "R3");
      xfer(8'hFF, exp_mem[32'h21], "R3");
      desel();

      // R4: program clears bits only
      sel();
      xfer(8'h02, 8'h00, "R9");
      addr3(32'h40, "R9");
      xfer(8'h0F, 8'h00, "R9"); exp_mem[32'h40] &= 8'h0F;
      xfer(8'hF0, 8'h00, "R9"); exp_mem[32'h41] &= 8'hF0;
      desel();
      rd_check(32'h40, 2, "R4");
      // R4: program wraps from the top address to zero
      sel();
      xfer(8'h02, 8'h00, "R9");
      addr3(AW'(MEMSZ - 1), "R9");
      xfer(8'h00, 8'h00, "R9"); exp_mem[MEMSZ-1] = 8'h00;
      xfer(8'h5A, 8'h00, "R9"); exp_mem[0] &= 8'h5A;
      desel();
      rd_check(MEMSZ - 1, 2, "R4");

      // R5: status write then looping status read
      sel(); xfer(8'h01, 8'h00, "R9"); xfer(8'hA5, 8'h00, "R9"); desel();
      sel();
      xfer(8'h05, 8'h00, "R9");
      for (int i = 0; i < 3; i++) xfer(8'h00, 8'hA4, "R5");
      desel();

      // R6: four-byte addressing, then back to three bytes
      sel(); xfer(8'hB7, 8'h00, "R9"); desel();
      sel();
      xfer(8'h03, 8'h00, "R9");
      xfer(8'h00, 8'h00, "R6");
      addr3(32'h50, "R6");
      xfer(8'hFF, exp_mem[32'h50], "R6");
      desel();
      sel(); xfer(8'hE9, 8'h00, "R9"); desel();
      rd_check(32'h60, 1, "R6");

      // R7: unknown opcode, later bytes not decoded
      sel();
      xfer(8'h9F, 8'h00, "R9");
      xfer(8'hB7, 8'h00, "R7");
      xfer(8'h01, 8'h00, "R7");
      xfer(8'h00, 8'h00, "R7");
      desel();
      sel(); xfer(8'h05, 8'h00, "R9"); xfer(8'h00, 8'hA4, "R7"); desel();
      rd_check(32'h70, 1, "R7");

      // R8: strobes while deselected are ignored; deselect ends program phase
      ghost(8'h05);
      sel();
      xfer(8'h02, 8'h00, "R9");
      addr3(32'h100, "R9");
      desel();
      ghost(8'h00);
      rd_check(32'h100, 1, "R8");

      repeat (4) @(negedge clk);
      tests++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R9: %0d responses missing, expected 0", exp_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule